// File: doc/BRIEF.md
# Multi-Pipe Interrupt Source Aggregator

This block folds the interrupt state of a set of DMA pipes, together with a small group of controller-wide events, into one level-sensitive interrupt line per execution environment. Every pipe presents a vector of status bits and a matching vector of enable bits. The block reduces each pipe to a single pending bit. The controller-wide events (timer, empty, error, bus-response error) are latched into a global status register. They are qualified by a global enable register and are cleared through a write-one-to-clear register. The qualified global result becomes one further pending bit.

Each execution environment owns a mask register and a source register. The mask chooses which pipes, and whether the global event, may reach that environment's interrupt line. The source register shows the pending bits that pass the mask. Interrupt-handling software in an environment reads its source register to find the pipes that need service. It clears the causes at the pipes or in the global clear register, and the line falls once nothing unmasked remains pending. A plain register port with a 12-bit byte address reaches all registers. Reads are combinational. Writes take effect at the clock edge.

Top module: `irq_src_aggregator`

## Requirements
- R1: The pending bit of pipe n is the OR over its status bits ANDed with its enable bits. It falls as soon as the pipe's enabled status bits are all clear. Pipe n's status and enable bits sit at positions n*STAT_W to n*STAT_W+STAT_W-1 of the flat status and enable inputs.
- R2: A pulse on glb_evt_i bit k sets global status bit k+1, and the bit then holds until it is cleared. Bit 4 is timer, bit 3 empty, bit 2 error and bit 1 bus-response error. Bit 0 and bits 31:5 of the global status register (0x020) always read 0.
- R3: A write to the global clear register (0x028) clears exactly those global status bits whose written bit is 1. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R4: The global enable register (0x024) can be read and written in bits 4:1, and its other bits read 0. The global pending bit is high when any global status bit is set together with its enable bit.
- R5: The source register of environment e is at 0x800 + e*0x80. Bits 30:0 hold the pipe pending bits and bit 31 holds the global pending bit, each ANDed with the environment's mask. Bits for pipes at or above NPIPE read 0.
- R6: The mask register of environment e is at 0x804 + e*0x80. It can be read and written in bit 31 and in bits NPIPE-1:0, and its other bits read 0. Each environment's mask affects only that environment.
- R7: irq_o[e] is a level. It rises one clock edge after any bit of environment e's source register becomes set. It stays high while any bit remains set, and it falls one edge after all bits are clear.
- R8: The revision register (0x000) reads the environment count NEE in bits 11:8 and the REV parameter in bits 7:0. The pipe-count register (0x004) reads NPIPE in bits 7:0.
- R9: After reset all mask registers, the global status register and the global enable register are 0, and every irq_o bit is low.
- R10: Writes to read-only registers (revision, pipe count, global status, source) have no effect. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_stat_i | input | NPIPE*STAT_W | Per-pipe status bits, pipe n at bits n*STAT_W upward |
| pipe_en_i | input | NPIPE*STAT_W | Per-pipe enable bits, same layout as status |
| glb_evt_i | input | 4 | Global event pulses; bit k sets global status bit k+1 |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i (combinational) |
| irq_o | output | NEE | Interrupt line per execution environment |

## Verification
The embedded properties check on every cycle that global status bits are set, held and cleared with event priority. They also check that enable and mask writes land with the legal-bit filtering, that masks do not drift without a write, that the interrupt line follows its source register one edge later in both directions, and that writes aimed at the status register do not disturb it. Only the bench scenarios show the combinational pieces. These are the reduction of each pipe's status against its enable, the placement of bits in the source registers, the per-environment address decode, the contents of the identification registers, the zero reads of unmapped addresses and the separation between environments.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int WORD_W  = 32;
   localparam int ADDR_W  = 12;
   localparam int GLB_BIT = 31;
   localparam int EVT_N   = 4;
   localparam int EVT_LSB = 1;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [ADDR_W-1:0] addr_t;

   localparam addr_t OFS_REV    = 12'h000;
   localparam addr_t OFS_PCNT   = 12'h004;
   localparam addr_t OFS_GSTAT  = 12'h020;
   localparam addr_t OFS_GEN    = 12'h024;
   localparam addr_t OFS_GCLR   = 12'h028;
   localparam addr_t OFS_EE_SRC = 12'h800;
   localparam addr_t OFS_EE_MSK = 12'h804;
   localparam addr_t EE_STRIDE  = 12'h080;

   function automatic addr_t ee_src_addr(input int e);
      return addr_t'(OFS_EE_SRC + addr_t'(e) * EE_STRIDE);
   endfunction

   function automatic addr_t ee_msk_addr(input int e);
      return addr_t'(OFS_EE_MSK + addr_t'(e) * EE_STRIDE);
   endfunction
endpackage

// File: rtl/irqagg_pipe_reduce.sv
module irqagg_pipe_reduce #(
   parameter int NPIPE  = 31,
   parameter int STAT_W = 6
) (
   input  logic [NPIPE*STAT_W-1:0] stat_i,
   input  logic [NPIPE*STAT_W-1:0] en_i,
   output logic [NPIPE-1:0]        pend_o
);
   generate
      if (STAT_W < 1) begin : g_bad
         $error("irqagg_pipe_reduce: STAT_W must be at least 1");
      end
      for (genvar n = 0; n < NPIPE; n++) begin : g_pipe
         if (STAT_W == 1) begin : g_single
            assign pend_o[n] = stat_i[n] & en_i[n];
         end else begin : g_multi
            logic [STAT_W-1:0] qual;
            assign qual      = stat_i[n*STAT_W +: STAT_W] & en_i[n*STAT_W +: STAT_W];
            assign pend_o[n] = |qual;
         end
      end
   endgenerate
endmodule

// File: rtl/irqagg_glb_evt.sv
module irqagg_glb_evt
   import irqagg_pkg::*;
#(
   parameter int NEVT = EVT_N
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NEVT-1:0] evt_i,
   input  logic            en_we_i,
   input  logic            clr_we_i,
   input  logic [NEVT-1:0] wbits_i,
   output logic [NEVT-1:0] stat_o,
   output logic [NEVT-1:0] en_o,
   output logic            pend_o
);
   logic [NEVT-1:0] stat_q, en_q;
   logic [NEVT-1:0] clr_mask;

   assign clr_mask = clr_we_i ? wbits_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         en_q   <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_mask) | evt_i;
         if (en_we_i) en_q <= wbits_i;
      end
   end

   assign stat_o = stat_q;
   assign en_o   = en_q;
   assign pend_o = |(stat_q & en_q);

   generate
      for (genvar i = 0; i < NEVT; i++) begin : g_chk
         AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> stat_q[i]); // R2
         AST_EVT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !(clr_we_i && wbits_i[i])) |=> stat_q[i]); // R2
         AST_CLR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && wbits_i[i] && !evt_i[i]) |=> !stat_q[i]); // R3
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && wbits_i[i] && evt_i[i]) |=> stat_q[i]); // R3
      end
   endgenerate

   AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      en_we_i |=> (en_q == $past(wbits_i))); // R4
endmodule

// File: rtl/irqagg_ee_slot.sv
module irqagg_ee_slot
   import irqagg_pkg::*;
#(
   parameter int NPIPE   = 31,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  msk_we_i,
   input  word_t wdata_i,
   input  word_t raw_i,
   output word_t msk_o,
   output word_t src_o,
   output logic  irq_o
);
   localparam word_t PIPE_BITS = word_t'((64'd1 << NPIPE) - 64'd1);
   localparam word_t LEGAL     = PIPE_BITS | (word_t'(1) << GLB_BIT);

   word_t msk_q;
   logic  any_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        msk_q <= '0;
      else if (msk_we_i) msk_q <= wdata_i & LEGAL;
   end

   assign msk_o   = msk_q;
   assign src_o   = raw_i & msk_q;
   assign any_src = |src_o;

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_src;
         end
         assign irq_o = irq_q;

         AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            any_src |=> irq_o); // R7
         AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            !any_src |=> !irq_o); // R7
      end else begin : g_comb
         assign irq_o = any_src;
      end
   endgenerate

   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      msk_we_i |=> (msk_q == ($past(wdata_i) & LEGAL))); // R6
   AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !msk_we_i |=> $stable(msk_q)); // R6
endmodule

// File: rtl/irq_src_aggregator.sv
module irq_src_aggregator
   import irqagg_pkg::*;
#(
   parameter int          NPIPE   = 31,
   parameter int          NEE     = 4,
   parameter int          STAT_W  = 6,
   parameter logic [7:0]  REV     = 8'h14,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPIPE*STAT_W-1:0] pipe_stat_i,
   input  logic [NPIPE*STAT_W-1:0] pipe_en_i,
   input  logic [EVT_N-1:0]        glb_evt_i,
   input  logic                    bus_wr_i,
   input  logic [ADDR_W-1:0]       bus_addr_i,
   input  logic [WORD_W-1:0]       bus_wdata_i,
   output logic [WORD_W-1:0]       bus_rdata_o,
   output logic [NEE-1:0]          irq_o
);
   generate
      if (NPIPE < 1 || NPIPE > GLB_BIT) begin : g_bad_npipe
         $error("irq_src_aggregator: NPIPE must be 1..31");
      end
      if (NEE < 1 || NEE > 15) begin : g_bad_nee
         $error("irq_src_aggregator: NEE must be 1..15");
      end
   endgenerate

   logic [NPIPE-1:0] pipe_pend;
   logic [EVT_N-1:0] gstat, gen;
   logic             glb_pend;
   word_t            raw_src;
   word_t            ee_src [NEE];
   word_t            ee_msk [NEE];
   logic             gen_we, gclr_we;
   word_t            gstat_w, gen_w;

   irqagg_pipe_reduce #(.NPIPE(NPIPE), .STAT_W(STAT_W)) u_reduce (
      .stat_i (pipe_stat_i),
      .en_i   (pipe_en_i),
      .pend_o (pipe_pend)
   );

   assign gen_we  = bus_wr_i && (bus_addr_i == OFS_GEN);
   assign gclr_we = bus_wr_i && (bus_addr_i == OFS_GCLR);

   irqagg_glb_evt #(.NEVT(EVT_N)) u_glb (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (glb_evt_i),
      .en_we_i  (gen_we),
      .clr_we_i (gclr_we),
      .wbits_i  (bus_wdata_i[EVT_LSB +: EVT_N]),
      .stat_o   (gstat),
      .en_o     (gen),
      .pend_o   (glb_pend)
   );

   always_comb begin
      raw_src                = '0;
      raw_src[NPIPE-1:0]     = pipe_pend;
      raw_src[GLB_BIT]       = glb_pend;
   end

   generate
      for (genvar e = 0; e < NEE; e++) begin : g_ee
         logic msk_we;
         assign msk_we = bus_wr_i && (bus_addr_i == ee_msk_addr(e));
         irqagg_ee_slot #(.NPIPE(NPIPE), .IRQ_REG(IRQ_REG)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .msk_we_i (msk_we),
            .wdata_i  (bus_wdata_i),
            .raw_i    (raw_src),
            .msk_o    (ee_msk[e]),
            .src_o    (ee_src[e]),
            .irq_o    (irq_o[e])
         );
      end
   endgenerate

   always_comb begin
      gstat_w = '0;
      gstat_w[EVT_LSB +: EVT_N] = gstat;
      gen_w = '0;
      gen_w[EVT_LSB +: EVT_N] = gen;
   end

   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         OFS_REV:   bus_rdata_o = {20'd0, 4'(NEE), REV};
         OFS_PCNT:  bus_rdata_o = {24'd0, 8'(NPIPE)};
         OFS_GSTAT: bus_rdata_o = gstat_w;
         OFS_GEN:   bus_rdata_o = gen_w;
         default:   bus_rdata_o = '0;
      endcase
      for (int e = 0; e < NEE; e++) begin
         if (bus_addr_i == ee_src_addr(e)) bus_rdata_o = ee_src[e];
         if (bus_addr_i == ee_msk_addr(e)) bus_rdata_o = ee_msk[e];
      end
   end

   AST_GSTAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == OFS_GSTAT && glb_evt_i == '0) |=> $stable(gstat)); // R10
endmodule

// File: tb/irq_src_aggregator_test.sv
module irq_src_aggregator_test;
   import irqagg_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NP  = 8;
   localparam int NE  = 2;
   localparam int SW  = 3;
   localparam logic [7:0] REVV = 8'h2A;
   localparam int NV  = 10;

   // vector: {stat[23:0], en[23:0], mask0[31:0], exp_src0[31:0], exp_irq0}
   localparam logic [112:0] VECS [0:NV-1] = '{
      {24'h000000, 24'hFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0},
      {24'h000001, 24'hFFFFFF, 32'hFFFFFFFF, 32'h00000001, 1'b1},
      {24'h000001, 24'hFFFFFE, 32'hFFFFFFFF, 32'h00000000, 1'b0},
      {24'h800000, 24'hFFFFFF, 32'hFFFFFFFF, 32'h00000080, 1'b1},
      {24'h800000, 24'hFFFFFF, 32'h0000007F, 32'h00000000, 1'b0},
      {24'h008080, 24'hFFFFFF, 32'h00000024, 32'h00000024, 1'b1},
      {24'h008080, 24'hFFFFFF, 32'h00000004, 32'h00000004, 1'b1},
      {24'h008080, 24'h038000, 32'hFFFFFFFF, 32'h00000020, 1'b1},
      {24'hFFFFFF, 24'hFFFFFF, 32'h00000000, 32'h00000000, 1'b0},
      {24'hFFFFFF, 24'hFFFFFF, 32'hFFFFFFFF, 32'h000000FF, 1'b1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP*SW-1:0] pipe_stat = '0;
   logic [NP*SW-1:0] pipe_en = '0;
   logic [3:0]       glb_evt = '0;
   logic             bus_wr = 1'b0;
   logic [11:0]      bus_addr = '0;
   logic [31:0]      bus_wdata = '0;
   logic [31:0]      bus_rdata;
   logic [NE-1:0]    irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_src_aggregator #(.NPIPE(NP), .NEE(NE), .STAT_W(SW), .REV(REVV), .IRQ_REG(1'b1)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .pipe_stat_i (pipe_stat),
      .pipe_en_i   (pipe_en),
      .glb_evt_i   (glb_evt),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_o       (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      cyc();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(input logic [3:0] v);
      glb_evt = v;
      cyc();
      glb_evt = '0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      chk("R9 irq after reset", 32'(irq), 32'h0);
      rd(12'h804, d); chk("R9 mask0 reset", d, 32'h0);
      rd(12'h884, d); chk("R9 mask1 reset", d, 32'h0);
      rd(OFS_GSTAT, d); chk("R9 gstat reset", d, 32'h0);
      rd(OFS_GEN, d); chk("R9 gen reset", d, 32'h0);
      // R8 identification
      rd(OFS_REV, d); chk("R8 revision", d, 32'h0000022A);
      rd(OFS_PCNT, d); chk("R8 pipe count", d, 32'h00000008);

      // R1 R5 R7 vector table
      for (int i = 0; i < NV; i++) begin
         pipe_stat = VECS[i][112:89];
         pipe_en   = VECS[i][88:65];
         wr(12'h804, VECS[i][64:33]);
         cyc();
         rd(12'h800, d); chk($sformatf("R1/R5 vec%0d src0", i), d, VECS[i][32:1]);
         chk($sformatf("R7 vec%0d irq0", i), 32'(irq[0]), 32'(VECS[i][0]));
         chk($sformatf("R6 vec%0d irq1 independent", i), 32'(irq[1]), 32'h0);
      end
      pipe_stat = '0;
      pipe_en   = '1;

      // R6 legal bits of mask
      wr(12'h884, 32'hFFFFFFFF);
      rd(12'h884, d); chk("R6 mask1 legal bits", d, 32'h800000FF);
      wr(12'h884, 32'h0);

      // R2 event latch
      pulse(4'b1011);
      rd(OFS_GSTAT, d); chk("R2 gstat after events", d, 32'h00000016);
      cyc();
      rd(OFS_GSTAT, d); chk("R2 gstat holds", d, 32'h00000016);

      // R4 enable gating and legal bits
      wr(12'h804, 32'h80000000);
      cyc();
      rd(12'h800, d); chk("R4 no global pend with enable 0", d, 32'h0);
      chk("R4 irq0 low with enable 0", 32'(irq[0]), 32'h0);
      wr(OFS_GEN, 32'hFFFFFFFF);
      rd(OFS_GEN, d); chk("R4 gen legal bits", d, 32'h0000001E);
      wr(OFS_GEN, 32'h00000004);
      cyc();
      rd(12'h800, d); chk("R5 global bit in src0", d, 32'h80000000);
      chk("R4 irq0 from error event", 32'(irq[0]), 32'h1);

      // R3 clear exactly
      wr(OFS_GCLR, 32'h00000002);
      rd(OFS_GSTAT, d); chk("R3 clear bus-error only", d, 32'h00000014);
      wr(OFS_GCLR, 32'h00000004);
      rd(OFS_GSTAT, d); chk("R3 clear error only", d, 32'h00000010);
      rd(12'h800, d); chk("R4 global pend gone", d, 32'h0);
      chk("R7 irq0 one edge late fall", 32'(irq[0]), 32'h1);
      cyc();
      chk("R7 irq0 fell", 32'(irq[0]), 32'h0);

      // R3 event beats simultaneous clear
      glb_evt = 4'b1000;
      bus_wr = 1'b1; bus_addr = OFS_GCLR; bus_wdata = 32'h00000010;
      cyc();
      bus_wr = 1'b0; glb_evt = '0;
      rd(OFS_GSTAT, d); chk("R3 set wins over clear", d, 32'h00000010);
      wr(OFS_GCLR, 32'h00000010);
      rd(OFS_GSTAT, d); chk("R3 cleared afterwards", d, 32'h0);

      // R10 read-only and unmapped
      pulse(4'b0001);
      wr(OFS_GSTAT, 32'h0);
      rd(OFS_GSTAT, d); chk("R10 gstat write ignored", d, 32'h00000002);
      wr(12'h800, 32'hFFFFFFFF);
      rd(12'h804, d); chk("R10 src write leaves mask0", d, 32'h80000000);
      wr(OFS_REV, 32'h0);
      rd(OFS_REV, d); chk("R10 revision write ignored", d, 32'h0000022A);
      rd(12'h100, d); chk("R10 unmapped reads zero", d, 32'h0);
      wr(OFS_GCLR, 32'h00000002);

      // R7 level timing with a pipe source, R1 clear follows status
      wr(12'h804, 32'h000000FF);
      cyc();
      pipe_stat = 24'h000200;  // pipe3 bit0
      #1;
      chk("R7 irq0 not yet risen", 32'(irq[0]), 32'h0);
      rd(12'h800, d); chk("R1 pipe3 pending", d, 32'h00000008);
      cyc();
      chk("R7 irq0 risen", 32'(irq[0]), 32'h1);
      cyc();
      chk("R7 irq0 level held", 32'(irq[0]), 32'h1);
      pipe_stat = '0;
      rd(12'h800, d); chk("R1 pending clears with status", d, 32'h0);
      chk("R7 irq0 still high until edge", 32'(irq[0]), 32'h1);
      cyc();
      chk("R7 irq0 low after clear", 32'(irq[0]), 32'h0);

      // R6 environment 1 sees the same pipe only via its own mask
      wr(12'h884, 32'h00000008);
      pipe_stat = 24'h000200;
      cyc();
      chk("R6 irq1 via own mask", 32'(irq[1]), 32'h1);
      rd(12'h880, d); chk("R5 src1 address", d, 32'h00000008);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule